// File: doc/BRIEF.md
# Preamble-and-Checksum FSK Frame Serializer

This block sits between a host and an FSK radio transmitter. It sends one packet, one bit at a time, on a single modulation pin. The host writes a fixed-size payload into an internal byte bank through a load port and then pulses a start strobe. The block raises a transmitter-enable request and builds the frame in hardware. The frame is made of alternating-pattern lead-in bytes, a two-byte sync word, the stored payload, an additive checksum over the payload, and alternating-pattern tail bytes. Every byte goes out most significant bit first.

The block has no internal baud timer. The radio paces the bits with an active-low request line. After that line has gone low and then returned high, the block drives the next bit onto the modulation pin. The request line passes through a two-flop synchronizer before its edge is detected.

When the radio asks for one more bit after the final tail bit, the block drops transmitter-enable and returns the modulation pin to its high idle level. It then pulses done for one clock and becomes ready for the next packet.

Top module: `fsk_frame_tx`

## Requirements
- R1: After reset, and whenever busy is low, the modulation pin is high, transmitter-enable is low and done is low.
- R2: One frame is 192 bits, sent in this order: three 0xAA bytes, byte 0x2D, byte 0xD4, the 16 stored payload bytes from address 0 upward, one checksum byte, and then two 0xAA bytes.
- R3: Each byte is sent most significant bit first.
- R4: The modulation pin changes only after the synchronized request line has been seen low and then high. Each such low-then-high cycle presents exactly one bit. A request line that stays high, or stays low, changes nothing.
- R5: The checksum byte is the sum of the 16 payload bytes, modulo 256. The lead-in, sync and tail bytes are not part of this sum.
- R6: A start strobe accepted in idle sets busy and transmitter-enable on the next clock, before any bit is presented. Transmitter-enable stays high while the final tail bit is presented. It falls on the first request cycle after that final bit.
- R7: Busy stays high from the accepted start until the done cycle, including the done cycle. Busy is low in the cycle after done.
- R8: Payload writes (load_en_i high) are ignored while busy is high, so the stored byte keeps its earlier value.
- R9: A start strobe while busy is high is ignored. It does not restart the frame, and it is not remembered for later.
- R10: Done is high for exactly one clock per frame. That clock is the first clock in which transmitter-enable is low again.
- R11: The modulation pin returns high in the same clock in which transmitter-enable falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe for one frame |
| load_en_i | input | 1 | Payload byte write enable |
| load_addr_i | input | ADDR_W | Payload byte address |
| load_data_i | input | 8 | Payload byte value |
| req_n_i | input | 1 | Active-low bit request from the radio (asynchronous) |
| fsk_o | output | 1 | Serial modulation bit |
| tx_en_o | output | 1 | Transmitter-enable request |
| busy_o | output | 1 | A frame is in progress |
| done_o | output | 1 | One-clock end-of-frame pulse |

## Verification
The assertions run on every cycle. They check that the modulation pin only moves after a detected request edge, and that the pin is high and transmitter-enable is low in idle. They also check that an accepted start raises busy and enable, that busy holds until done, and that done is a single clock that follows the fall of enable.

Some behaviour can only be shown by the bench scenarios, which compare the bits against a queue of expected values. These are the exact bit order of the frame and the checksum value, including a payload whose sum wraps past 255. The scenarios also show that a write or a start issued in mid-frame leaves both the stream and the stored byte unchanged.

// File: rtl/fsk_frame_pkg.sv
package fsk_frame_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_TAIL = 2'd2,
    ST_FIN  = 2'd3
  } fsk_state_t;

  localparam logic [7:0]  DEF_FILL_BYTE = 8'hAA;
  localparam logic [15:0] DEF_SYNC_WORD = 16'h2DD4;

endpackage

// File: rtl/fsk_req_sync.sv
module fsk_req_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_n_i,
  input  logic arm_i,
  output logic bit_tick_o
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;
  logic              low_seen_q;
  logic              low_seen_d;
  logic              req_s;

  assign req_s = chain_q[STAGES-1];

  always_comb begin
    chain_d    = {chain_q[STAGES-2:0], req_n_i};
    low_seen_d = arm_i & ~req_s;
    bit_tick_o = arm_i & low_seen_q & req_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q    <= '1;
      low_seen_q <= 1'b0;
    end else begin
      chain_q    <= chain_d;
      low_seen_q <= low_seen_d;
    end
  end

endmodule

// File: rtl/fsk_payload_bank.sv
module fsk_payload_bank #(
  parameter int BYTES  = 16,
  parameter int ADDR_W = $clog2(BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [7:0]        rd_data_o
);

  logic [7:0] slot_q [BYTES];

  for (genvar g = 0; g < BYTES; g++) begin : g_slot
    logic       slot_we;
    assign slot_we = wr_en_i && (wr_addr_i == ADDR_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_q[g] <= 8'h00;
      end else if (slot_we) begin
        slot_q[g] <= wr_data_i;
      end
    end
  end

  always_comb begin
    if (int'(rd_addr_i) < BYTES) rd_data_o = slot_q[rd_addr_i];
    else                         rd_data_o = 8'h00;
  end

endmodule

// File: rtl/fsk_frame_seq.sv
module fsk_frame_seq
  import fsk_frame_pkg::*;
#(
  parameter int          LEAD_BYTES  = 3,
  parameter int          BYTES       = 16,
  parameter int          TAIL_BYTES  = 2,
  parameter int          ADDR_W      = $clog2(BYTES),
  parameter logic [7:0]  FILL_BYTE   = DEF_FILL_BYTE,
  parameter logic [15:0] SYNC_WORD   = DEF_SYNC_WORD
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              bit_tick_i,
  input  logic [7:0]        pay_byte_i,
  output logic [ADDR_W-1:0] pay_addr_o,
  output logic              arm_o,
  output logic              fsk_o,
  output logic              tx_en_o,
  output logic              busy_o,
  output logic              done_o
);

  localparam int TOTAL = LEAD_BYTES + 2 + BYTES + 1 + TAIL_BYTES;
  localparam int IW    = $clog2(TOTAL);
  localparam logic [IW-1:0] IDX_SYNC_HI = IW'(LEAD_BYTES);
  localparam logic [IW-1:0] IDX_SYNC_LO = IW'(LEAD_BYTES + 1);
  localparam logic [IW-1:0] IDX_PAY     = IW'(LEAD_BYTES + 2);
  localparam logic [IW-1:0] IDX_CK      = IW'(LEAD_BYTES + 2 + BYTES);
  localparam logic [IW-1:0] IDX_LAST    = IW'(TOTAL - 1);

  fsk_state_t    state_q, state_d;
  logic [IW-1:0] byte_q,  byte_d;
  logic [2:0]    bit_q,   bit_d;
  logic [7:0]    acc_q,   acc_d;
  logic          fsk_q,   fsk_d;
  logic          txen_q,  txen_d;
  logic          done_q,  done_d;

  logic [7:0]    cur_byte;
  logic          in_payload;
  logic [IW-1:0] pay_off;

  assign in_payload = (byte_q >= IDX_PAY) && (byte_q < IDX_CK);
  assign pay_off    = byte_q - IDX_PAY;
  assign pay_addr_o = pay_off[ADDR_W-1:0];

  always_comb begin
    if (byte_q < IDX_SYNC_HI)       cur_byte = FILL_BYTE;
    else if (byte_q == IDX_SYNC_HI) cur_byte = SYNC_WORD[15:8];
    else if (byte_q == IDX_SYNC_LO) cur_byte = SYNC_WORD[7:0];
    else if (in_payload)            cur_byte = pay_byte_i;
    else if (byte_q == IDX_CK)      cur_byte = acc_q;
    else                            cur_byte = FILL_BYTE;
  end

  always_comb begin
    state_d = state_q;
    byte_d  = byte_q;
    bit_d   = bit_q;
    acc_d   = acc_q;
    fsk_d   = fsk_q;
    txen_d  = txen_q;
    done_d  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d = ST_SEND;
          txen_d  = 1'b1;
          byte_d  = '0;
          bit_d   = '0;
          acc_d   = '0;
        end
      end
      ST_SEND: begin
        if (bit_tick_i) begin
          fsk_d = cur_byte[~bit_q];
          if (bit_q == 3'd7) begin
            bit_d = '0;
            if (in_payload) acc_d = acc_q + cur_byte;
            if (byte_q == IDX_LAST) state_d = ST_TAIL;
            else                    byte_d  = byte_q + 1'b1;
          end else begin
            bit_d = bit_q + 1'b1;
          end
        end
      end
      ST_TAIL: begin
        if (bit_tick_i) begin
          state_d = ST_FIN;
          txen_d  = 1'b0;
          fsk_d   = 1'b1;
          done_d  = 1'b1;
        end
      end
      ST_FIN: begin
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      byte_q  <= '0;
      bit_q   <= '0;
      acc_q   <= '0;
      fsk_q   <= 1'b1;
      txen_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      byte_q  <= byte_d;
      bit_q   <= bit_d;
      acc_q   <= acc_d;
      fsk_q   <= fsk_d;
      txen_q  <= txen_d;
      done_q  <= done_d;
    end
  end

  assign arm_o   = (state_q == ST_SEND) || (state_q == ST_TAIL);
  assign busy_o  = (state_q != ST_IDLE);
  assign fsk_o   = fsk_q;
  assign tx_en_o = txen_q;
  assign done_o  = done_q;

endmodule

// File: rtl/fsk_frame_tx.sv
module fsk_frame_tx
  import fsk_frame_pkg::*;
#(
  parameter int          PAYLOAD_BYTES = 16,
  parameter int          LEAD_BYTES    = 3,
  parameter int          TAIL_BYTES    = 2,
  parameter int          SYNC_STAGES   = 2,
  parameter logic [7:0]  FILL_BYTE     = DEF_FILL_BYTE,
  parameter logic [15:0] SYNC_WORD     = DEF_SYNC_WORD,
  parameter int          ADDR_W        = $clog2(PAYLOAD_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              load_en_i,
  input  logic [ADDR_W-1:0] load_addr_i,
  input  logic [7:0]        load_data_i,
  input  logic              req_n_i,
  output logic              fsk_o,
  output logic              tx_en_o,
  output logic              busy_o,
  output logic              done_o
);

  logic              bit_tick;
  logic              arm;
  logic              bank_we;
  logic [ADDR_W-1:0] rd_addr;
  logic [7:0]        rd_byte;

  assign bank_we = load_en_i & ~busy_o;

  fsk_req_sync #(
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_n_i    (req_n_i),
    .arm_i      (arm),
    .bit_tick_o (bit_tick)
  );

  fsk_payload_bank #(
    .BYTES  (PAYLOAD_BYTES),
    .ADDR_W (ADDR_W)
  ) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (bank_we),
    .wr_addr_i (load_addr_i),
    .wr_data_i (load_data_i),
    .rd_addr_i (rd_addr),
    .rd_data_o (rd_byte)
  );

  fsk_frame_seq #(
    .LEAD_BYTES (LEAD_BYTES),
    .BYTES      (PAYLOAD_BYTES),
    .TAIL_BYTES (TAIL_BYTES),
    .ADDR_W     (ADDR_W),
    .FILL_BYTE  (FILL_BYTE),
    .SYNC_WORD  (SYNC_WORD)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .bit_tick_i (bit_tick),
    .pay_byte_i (rd_byte),
    .pay_addr_o (rd_addr),
    .arm_o      (arm),
    .fsk_o      (fsk_o),
    .tx_en_o    (tx_en_o),
    .busy_o     (busy_o),
    .done_o     (done_o)
  );

endmodule

// File: rtl/fsk_frame_chk.sv
module fsk_frame_chk (
  input logic clk,
  input logic rst_n,
  input logic start_i,
  input logic bit_tick,
  input logic fsk_o,
  input logic tx_en_o,
  input logic busy_o,
  input logic done_o
);

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (fsk_o && !tx_en_o && !done_o));

  p_bit_paced_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(fsk_o) |-> $past(bit_tick));

  p_start_accept_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && start_i) |=> (busy_o && tx_en_o && fsk_o));

  p_busy_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !done_o) |=> busy_o);

  p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !busy_o);

  p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_done_after_en_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!tx_en_o && $past(tx_en_o)));

  p_pin_high_on_drop_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_en_o) |-> fsk_o);

endmodule

bind fsk_frame_tx fsk_frame_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start_i  (start_i),
  .bit_tick (bit_tick),
  .fsk_o    (fsk_o),
  .tx_en_o  (tx_en_o),
  .busy_o   (busy_o),
  .done_o   (done_o)
);

// File: tb/sim_fsk_frame_tx.sv
module sim_fsk_frame_tx;

  logic       clk;
  logic       rst_n;
  logic       start_i;
  logic       load_en_i;
  logic [3:0] load_addr_i;
  logic [7:0] load_data_i;
  logic       req_n_i;
  logic       fsk_o;
  logic       tx_en_o;
  logic       busy_o;
  logic       done_o;

  int n_chk;
  int n_err;
  int pulse_cnt;
  int seen_cnt;
  int done_cnt;
  bit done_with_en;
  bit ended;
  logic exp_q[$];
  logic [7:0] pay[16];

  fsk_frame_tx u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .load_en_i   (load_en_i),
    .load_addr_i (load_addr_i),
    .load_data_i (load_data_i),
    .req_n_i     (req_n_i),
    .fsk_o       (fsk_o),
    .tx_en_o     (tx_en_o),
    .busy_o      (busy_o),
    .done_o      (done_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  endtask

  task automatic push_byte(input logic [7:0] b);
    for (int k = 7; k >= 0; k--) exp_q.push_back(b[k]);
  endtask

  // R2 R3 R5: expected stream built from the stated frame layout
  task automatic push_frame();
    logic [7:0] sum;
    sum = 8'h00;
    for (int k = 0; k < 3; k++) push_byte(8'hAA);
    push_byte(8'h2D);
    push_byte(8'hD4);
    for (int k = 0; k < 16; k++) begin
      push_byte(pay[k]);
      sum = sum + pay[k];
    end
    push_byte(sum);
    push_byte(8'hAA);
    push_byte(8'hAA);
  endtask

  task automatic load_byte(input int a, input logic [7:0] d);
    @(negedge clk);
    load_en_i   = 1'b1;
    load_addr_i = 4'(a);
    load_data_i = d;
    @(negedge clk);
    load_en_i   = 1'b0;
  endtask

  task automatic pulse_start();
    @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic req_pulse(input bit counted);
    @(negedge clk);
    req_n_i = 1'b0;
    repeat (4) @(negedge clk);
    req_n_i = 1'b1;
    repeat (6) @(negedge clk);
    if (counted) pulse_cnt++;
    repeat (3) @(negedge clk);
  endtask

  // monitor: pops one expected bit per counted request cycle
  initial begin
    forever begin
      @(negedge clk);
      if (done_o) begin
        done_cnt++;
        if (tx_en_o) done_with_en = 1'b1;
      end
      if (pulse_cnt > seen_cnt) begin
        logic e;
        seen_cnt++;
        if (exp_q.size() == 0) begin
          chk(1'b0, "R2 bit beyond frame", 32'(fsk_o), 32'hx);
        end else begin
          e = exp_q.pop_front();
          chk(fsk_o === e, "R2/R3 stream bit", 32'(fsk_o), 32'(e));
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  task automatic end_frame_checks();
    repeat (5) @(negedge clk);
    chk(exp_q.size() == 0, "R2 all bits sent", 32'(exp_q.size()), 0);
    chk(tx_en_o == 1'b1, "R6 enable held over last bit", 32'(tx_en_o), 1);
    chk(busy_o == 1'b1, "R7 busy before final request", 32'(busy_o), 1);
    done_cnt     = 0;
    done_with_en = 1'b0;
    req_pulse(1'b0);
    chk(tx_en_o == 1'b0, "R6 enable dropped", 32'(tx_en_o), 0);
    chk(fsk_o == 1'b1, "R11 pin high after drop", 32'(fsk_o), 1);
    chk(busy_o == 1'b0, "R7 busy released", 32'(busy_o), 0);
    chk(done_cnt == 1, "R10 single done", 32'(done_cnt), 1);
    chk(!done_with_en, "R10 done after enable low", 32'(done_with_en), 0);
  endtask

  initial begin
    n_chk = 0; n_err = 0; pulse_cnt = 0; seen_cnt = 0; done_cnt = 0;
    done_with_en = 1'b0; ended = 1'b0;
    rst_n = 1'b0; start_i = 1'b0; load_en_i = 1'b0; load_addr_i = '0;
    load_data_i = '0; req_n_i = 1'b1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(fsk_o == 1'b1, "R1 reset pin", 32'(fsk_o), 1);
    chk(tx_en_o == 1'b0, "R1 reset enable", 32'(tx_en_o), 0);
    chk(busy_o == 1'b0, "R1 reset busy", 32'(busy_o), 0);
    chk(done_o == 1'b0, "R1 reset done", 32'(done_o), 0);

    // frame 1: distinct bytes
    for (int i = 0; i < 16; i++) begin
      pay[i] = 8'(i * 17 + 3);
      load_byte(i, pay[i]);
    end
    push_frame();
    pulse_start();
    chk(busy_o == 1'b1, "R7 busy on start", 32'(busy_o), 1);
    chk(tx_en_o == 1'b1, "R6 enable before first bit", 32'(tx_en_o), 1);
    chk(fsk_o == 1'b1, "R6 no bit before request", 32'(fsk_o), 1);
    req_pulse(1'b1);
    // R4: request held high, then held low: bit must not advance (next bit is 0)
    repeat (20) @(negedge clk);
    chk(fsk_o == 1'b1, "R4 steady high request", 32'(fsk_o), 1);
    req_n_i = 1'b0;
    repeat (20) @(negedge clk);
    chk(fsk_o == 1'b1, "R4 steady low request", 32'(fsk_o), 1);
    req_n_i = 1'b1;
    repeat (6) @(negedge clk);
    pulse_cnt++;
    repeat (3) @(negedge clk);
    for (int i = 3; i <= 192; i++) begin
      if (i == 100) begin
        load_byte(0, 8'h55);   // R8: must be ignored
        pulse_start();         // R9: must be ignored
        chk(busy_o == 1'b1, "R9 busy kept", 32'(busy_o), 1);
      end
      req_pulse(1'b1);
    end
    end_frame_checks();
    repeat (20) @(negedge clk);
    chk(busy_o == 1'b0, "R9 start not remembered", 32'(busy_o), 0);
    chk(tx_en_o == 1'b0, "R9 no restart", 32'(tx_en_o), 0);

    // frame 2: slot 0 not reloaded (keeps 0x03, R8); high bytes make the sum wrap (R5)
    pay[0] = 8'h03;
    for (int i = 1; i < 16; i++) begin
      pay[i] = 8'(8'hF0 + i);
      load_byte(i, pay[i]);
    end
    push_frame();
    pulse_start();
    for (int i = 1; i <= 192; i++) req_pulse(1'b1);
    end_frame_checks();

    finish_run();
  end

endmodule